// File: doc/BRIEF.md
# Hypervisor Control Register File

This block is a small set of privileged control registers reached through a single-cycle address/data port. It holds a trap base address, a processor state word, a trap state word, a strand status word, the head and tail pointers of four interrupt queues, and a read-only version word. Each register applies its own fixed rule when it is written. The low fifteen bits of the trap base are always zero. One bit of the processor state word is always set. The version word is built from three configuration parameters.

A request is one cycle with `req_i` high. `we_i` selects a write or a read. Read data is registered and appears in the cycle after the request, then holds until the next read. Writing any queue pointer raises `recheck_o` for one cycle, telling the core to look again for pending interrupts. An access to an undefined address, or a write to the version word, raises `err_o` for one cycle and changes no state.

Top module: `hv_ctl_regfile`

## Requirements
- R1: After reset every writable register reads zero, except the processor state word, which reads 0x800 (bit 11 set). `rdata_o`, `err_o` and `recheck_o` are 0 after reset.
- R2: A write to the trap base (address 0) stores the data with bits 14:0 cleared, and a read of it returns bits 14:0 as zero.
- R3: A write to the processor state word (address 1) stores the data with bit 11 forced to 1.
- R4: The trap state word (address 2) and the strand status word (address 3) store written data unchanged and return it on read.
- R5: Addresses 8 to 15 are queue pointers. Address bits 2:1 pick the queue: 0 is processor mondo, 1 is device mondo, 2 is resumable error and 3 is non-resumable error. Address bit 0 picks the tail (1) or the head (0). Each pointer stores written data unchanged.
- R6: `recheck_o` is high for exactly the one cycle after a write to any queue pointer. It stays low after reads and after writes to other addresses.
- R7: A read of the version word (address 4) returns the window count in bits 7:0, the maximum trap level in bits 15:8 and the maximum global level in bits 23:16. All higher bits read as zero.
- R8: A write to the version word raises `err_o` for one cycle and leaves every register unchanged.
- R9: An access to address 5, 6 or 7 raises `err_o` for one cycle. Such a read returns zero, and such a write changes no register.
- R10: `rdata_o` changes only in the cycle after a read request. Writes leave it holding the last value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse after an illegal access |
| recheck_o | output | 1 | One-cycle pulse after a queue pointer write |

## Verification
Every result is due one clock edge after the request. This covers read data, the error pulse, the recheck pulse and the stored register value. The bench drives each request on a falling edge. It checks all three outputs on the next falling edge, just after the edge that registers them. On that same falling edge it clears the request or starts the next one. This means each pulse is checked in the single cycle it must be high. The pulse is then checked again as low on the following access. Effects that cannot be seen directly, such as ignored writes, are checked by reading the register back in a later access.

// File: rtl/hv_ctl_pkg.sv
package hv_ctl_pkg;
  localparam int ADDR_W = 4;
  localparam int NQ_PTR = 8;
  localparam int QIDX_W = $clog2(NQ_PTR);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TBA,
    SEL_HPS,
    SEL_HTS,
    SEL_STS,
    SEL_VER,
    SEL_QUE
  } sel_e;

  typedef struct packed {
    sel_e              sel;
    logic [QIDX_W-1:0] qidx;
    logic              legal;
  } dec_t;
endpackage

// File: rtl/hv_addr_decode.sv
module hv_addr_decode
  import hv_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.sel   = SEL_NONE;
    dec_o.qidx  = addr_i[QIDX_W-1:0];
    dec_o.legal = 1'b1;
    if (addr_i[ADDR_W-1]) begin
      dec_o.sel = SEL_QUE;
    end else begin
      unique case (addr_i[ADDR_W-2:0])
        3'd0:    dec_o.sel = SEL_TBA;
        3'd1:    dec_o.sel = SEL_HPS;
        3'd2:    dec_o.sel = SEL_HTS;
        3'd3:    dec_o.sel = SEL_STS;
        3'd4:    dec_o.sel = SEL_VER;
        default: begin
          dec_o.sel   = SEL_NONE;
          dec_o.legal = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hv_masked_reg.sv
module hv_masked_reg #(
  parameter int                DATA_W   = 64,
  parameter logic [DATA_W-1:0] CLR_MASK = '0,
  parameter logic [DATA_W-1:0] SET_MASK = '0,
  parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= (d_i & ~CLR_MASK) | SET_MASK;
  end

  // R8
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/hv_queue_ptrs.sv
module hv_queue_ptrs
  import hv_ctl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [QIDX_W-1:0]              idx_i,
  input  logic [DATA_W-1:0]              d_i,
  output logic [NQ_PTR-1:0][DATA_W-1:0]  q_o,
  output logic                           recheck_o
);
  for (genvar g = 0; g < NQ_PTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q_o[g] <= '0;
      else if (we_i && idx_i == QIDX_W'(g))     q_o[g] <= d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) recheck_o <= 1'b0;
    else         recheck_o <= we_i;
  end

  // R6
  recheck_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> recheck_o);
  // R6
  recheck_only_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recheck_o |-> $past(we_i));
endmodule

// File: rtl/hv_ctl_regfile.sv
module hv_ctl_regfile
  import hv_ctl_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int TBA_ZERO_W  = 15,
  parameter int HPS_FIX_BIT = 11,
  parameter int NWIN        = 8,
  parameter int MAX_TL      = 6,
  parameter int MAX_GL      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              recheck_o
);
  localparam logic [DATA_W-1:0] TBA_CLR = ~({DATA_W{1'b1}} << TBA_ZERO_W);
  localparam logic [DATA_W-1:0] HPS_SET = {{(DATA_W-1){1'b0}}, 1'b1} << HPS_FIX_BIT;
  localparam logic [7:0]        NWIN8   = 8'(NWIN);
  localparam logic [7:0]        TL8     = 8'(MAX_TL);
  localparam logic [7:0]        GL8     = 8'(MAX_GL);
  localparam logic [DATA_W-1:0] VER_VAL = DATA_W'({GL8, TL8, NWIN8});

  dec_t dec;
  logic wr_ok, rd_req, err_d;
  logic [DATA_W-1:0] tba_q, hps_q, hts_q, sts_q, rd_mux;
  logic [NQ_PTR-1:0][DATA_W-1:0] qptr_q;

  hv_addr_decode u_dec (.addr_i(addr_i), .dec_o(dec));

  assign wr_ok  = req_i && we_i && dec.legal && dec.sel != SEL_VER;
  assign rd_req = req_i && !we_i;
  assign err_d  = req_i && (!dec.legal || (we_i && dec.sel == SEL_VER));

  hv_masked_reg #(.DATA_W(DATA_W), .CLR_MASK(TBA_CLR)) u_tba (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && dec.sel == SEL_TBA),
    .d_i(wdata_i), .q_o(tba_q));

  hv_masked_reg #(.DATA_W(DATA_W), .SET_MASK(HPS_SET), .RST_VAL(HPS_SET)) u_hps (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && dec.sel == SEL_HPS),
    .d_i(wdata_i), .q_o(hps_q));

  hv_masked_reg #(.DATA_W(DATA_W)) u_hts (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && dec.sel == SEL_HTS),
    .d_i(wdata_i), .q_o(hts_q));

  hv_masked_reg #(.DATA_W(DATA_W)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && dec.sel == SEL_STS),
    .d_i(wdata_i), .q_o(sts_q));

  hv_queue_ptrs #(.DATA_W(DATA_W)) u_que (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && dec.sel == SEL_QUE),
    .idx_i(dec.qidx), .d_i(wdata_i), .q_o(qptr_q), .recheck_o(recheck_o));

  always_comb begin
    unique case (dec.sel)
      SEL_TBA: rd_mux = tba_q & ~TBA_CLR;
      SEL_HPS: rd_mux = hps_q;
      SEL_HTS: rd_mux = hts_q;
      SEL_STS: rd_mux = sts_q;
      SEL_VER: rd_mux = VER_VAL;
      SEL_QUE: rd_mux = qptr_q[dec.qidx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= err_d;
      if (rd_req) rdata_o <= rd_mux;
    end
  end

  // R2
  tba_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == 4'd0) |=> (rdata_o[TBA_ZERO_W-1:0] == '0));
  // R3
  hps_bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == 4'd1) |=> rdata_o[HPS_FIX_BIT]);
  // R7
  version_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == 4'd4) |=> (rdata_o == VER_VAL));
  // R8
  version_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 4'd4) |=> (err_o && !recheck_o));
  // R9
  undef_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i inside {4'd5, 4'd6, 4'd7}) |=> err_o);
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));
endmodule

// File: tb/hv_ctl_regfile_test.sv
module hv_ctl_regfile_test;
  localparam int W = 64;
  localparam int NW = 8, TL = 6, GL = 3;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic err, recheck;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] model [16];
  logic [W-1:0] last_rd;
  bit done = 0;

  always #10 clk = ~clk;

  hv_ctl_regfile #(.DATA_W(W), .NWIN(NW), .MAX_TL(TL), .MAX_GL(GL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .recheck_o(recheck));

  function automatic bit is_legal(logic [3:0] a);
    return a <= 4'd4 || a >= 4'd8;
  endfunction

  function automatic logic [W-1:0] ver_val();
    return W'({8'(GL), 8'(TL), 8'(NW)});
  endfunction

  function automatic logic [W-1:0] stored(logic [3:0] a, logic [W-1:0] d);
    if (a == 4'd0) return d & ~W'(64'h7FFF);
    if (a == 4'd1) return d | W'(64'h800);
    return d;
  endfunction

  function automatic logic [W-1:0] exp_read(logic [3:0] a);
    if (a == 4'd4) return ver_val();
    if (!is_legal(a)) return '0;
    return model[a];
  endfunction

  function automatic string tag_of(logic [3:0] a, bit w);
    if (a == 4'd0) return "R2";
    if (a == 4'd1) return "R3";
    if (a == 4'd2 || a == 4'd3) return "R4";
    if (a == 4'd4) return w ? "R8" : "R7";
    if (!is_legal(a)) return "R9";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit w, logic [3:0] a, logic [W-1:0] d);
    bit exp_err, exp_rc;
    logic [W-1:0] exp_rd;
    req = 1; we = w; addr = a; wdata = d;
    exp_err = !is_legal(a) || (w && a == 4'd4);
    exp_rc  = w && a >= 4'd8;
    exp_rd  = w ? last_rd : exp_read(a);
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    chk(exp_err ? tag_of(a, w) : "R9 no err", W'(err), W'(exp_err));
    chk("R6 recheck", W'(recheck), W'(exp_rc));
    chk(w ? "R10 hold" : tag_of(a, w), rdata, exp_rd);
    last_rd = exp_rd;
    if (w && is_legal(a) && a != 4'd4) model[a] = stored(a, d);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    model[1] = W'(64'h800);
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, '0);
    chk("R1 err", W'(err), '0);
    chk("R1 recheck", W'(recheck), '0);
    for (int a = 0; a < 16; a++) access(0, 4'(a), '0);
    // R2 trap base masking
    access(1, 4'd0, '1);
    access(0, 4'd0, '0);
    // R3 forced bit
    access(1, 4'd1, '0);
    access(0, 4'd1, '0);
    // R4
    access(1, 4'd2, 64'hDEAD_BEEF_0123_4567);
    access(1, 4'd3, 64'h0000_0000_0000_7FFF);
    access(0, 4'd2, '0);
    access(0, 4'd3, '0);
    // R5 / R6 every queue pointer, back-to-back writes
    for (int a = 8; a < 16; a++) access(1, 4'(a), W'(64'h1000 * a + a));
    for (int a = 8; a < 16; a++) access(0, 4'(a), '0);
    // R7 / R8 version write ignored
    access(1, 4'd4, '1);
    access(0, 4'd4, '0);
    // R9 undefined addresses
    for (int a = 5; a < 8; a++) begin
      access(1, 4'(a), '1);
      access(0, 4'(a), '0);
    end
    // random mix
    void'($urandom(32'd2718));
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] d;
      d = {$urandom, $urandom};
      access(bit'($urandom % 2), 4'($urandom % 16), d);
    end
    for (int a = 0; a < 16; a++) access(0, 4'(a), '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule